// File: doc/BRIEF.md
# Delay-Feedback Radix-2 Butterfly Stage

This block is the first stage of a streaming pipelined FFT/IFFT over 1024-point frames. It accepts one complex sample per transfer (signed fixed-point real and imaginary parts) and returns one complex sample per transfer. A half-frame feedback delay holds the first 512 samples of each frame. During the second half, each incoming sample is combined with the sample that arrived 512 transfers earlier. The sum leaves the stage at once. The difference goes back into the delay, so that it leaves during the first half of the following frame.

The feedback path has two parts: a one-transfer staging register, then a circular memory of 512 entries whose read pointer runs one slot ahead of its write pointer. Together they delay each value by exactly half a frame. Differences formed in the last quarter of a frame are rotated by a quarter turn before they are stored. FFT mode rotates by -j and IFFT mode rotates by +j.

The stream interfaces are valid/ready. A transfer (one step of the stage) happens on a clock edge where `in_valid` and `out_ready` are both high. `in_ready` simply mirrors `out_ready`. The output word is formed combinationally from the incoming word and the stored state, so `out_valid` never rises without `in_valid`. Back-pressure from downstream therefore stalls the source in the same cycle, and no data is lost or duplicated.

Top module: `sdf_bfly_stage`

## Requirements
- R1: After synchronous active-high reset, the frame position is 0, the first-frame flag is clear and the staging register is zero. Holding `in_valid` high right after reset shows `out_valid` low and a zero output.
- R2: During transfers 0..511 of the first frame after reset, `out_valid` is low and `out_re` and `out_im` are both 0.
- R3: At frame position p in 512..1023, `out_valid` equals `in_valid`. The output is the saturated sum of the sample accepted at position p-512 of the same frame and the present input.
- R4: At frame position p in 0..255 of any later frame, the output is the saturated difference (earlier sample minus later sample) formed at position p+512 of the previous frame, and `out_valid` equals `in_valid`.
- R5: A difference formed at position 768 or above is rotated before it is stored. With `inverse`=0 (FFT) the stored value is (im, -re). With `inverse`=1 (IFFT) it is (-im, re). `inverse` is sampled in the transfer that forms the difference, and these values appear at positions 256..511 of the next frame.
- R6: Sums, differences and the negation inside the rotation are each clipped to the range -32768..32767, with no scaling.
- R7: `in_ready` equals `out_ready`. A cycle without a transfer leaves the frame position, the pointers, the staging register and the memory unchanged. `out_valid` is low whenever `in_valid` is low.
- R8: The frame position wraps from 1023 to 0 and sets the first-frame flag. From then on, every frame repeats the same behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Stage can accept (mirrors out_ready) |
| in_re | input | 16 | Input real part, signed |
| in_im | input | 16 | Input imaginary part, signed |
| inverse | input | 1 | 0 = FFT (rotate by -j), 1 = IFFT (rotate by +j) |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream accepts |
| out_re | output | 16 | Output real part, signed |
| out_im | output | 16 | Output imaginary part, signed |

## Verification
The hardest case to reach is a rotated, saturated difference being released half a frame later. This requires a full frame of priming, then extreme inputs in the last quarter of the next frame with `inverse` toggled on every sample. The drain of those values is only visible in the frame after that. The stimulus therefore chains whole frames, and a bench model of frame memory and the difference list predicts every output. Stalls of both kinds (`in_valid` low and `out_ready` low) are interleaved through one whole frame. This shows that the delay line counts transfers rather than clock cycles.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  typedef enum logic [1:0] {
    PH_PRIME = 2'd0,
    PH_DRAIN = 2'd1,
    PH_MERGE = 2'd2
  } phase_e;

endpackage

// File: rtl/bf_seq_ctrl.sv
module bf_seq_ctrl
  import sdf_pkg::*;
#(
  parameter int LOG2N = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  output logic [LOG2N-2:0]   wr_ptr,
  output logic [LOG2N-2:0]   rd_ptr,
  output phase_e             phase,
  output logic               rotate
);
  localparam int AW = LOG2N - 1;
  localparam logic [LOG2N-1:0] LAST = '1;

  logic [LOG2N-1:0] pos;
  logic             primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      primed <= 1'b0;
      wr_ptr <= '0;
      rd_ptr <= AW'(1);
    end else if (step) begin
      pos    <= pos + 1'b1;
      wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr + 1'b1;
      if (pos == LAST) primed <= 1'b1;
    end
  end

  always_comb begin
    if (pos[LOG2N-1])  phase = PH_MERGE;
    else if (primed)   phase = PH_DRAIN;
    else               phase = PH_PRIME;
  end

  assign rotate = pos[LOG2N-1] & pos[LOG2N-2];

  assert_frame_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (step && pos == LAST) |=> (pos == '0 && primed));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(pos) && $stable(wr_ptr) && $stable(primed)));

  assert_ptr_gap_R4: assert property (@(posedge clk) disable iff (rst)
    rd_ptr == AW'(wr_ptr + 1'b1));

endmodule

// File: rtl/bf_delay_ram.sv
module bf_delay_ram #(
  parameter int W  = 32,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/bf_core.sv
module bf_core #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic                 rotate,
  input  logic                 inverse,
  output logic signed [DW-1:0] sum_re,
  output logic signed [DW-1:0] sum_im,
  output logic signed [DW-1:0] dif_re,
  output logic signed [DW-1:0] dif_im
);
  function automatic logic signed [DW-1:0] clip(input logic signed [DW:0] v);
    if (v[DW] != v[DW-1])
      return v[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    return v[DW-1:0];
  endfunction

  function automatic logic signed [DW:0] ext(input logic signed [DW-1:0] x);
    return {x[DW-1], x};
  endfunction

  logic signed [DW-1:0] d_re, d_im, nd_re, nd_im;

  always_comb begin
    sum_re = clip(ext(a_re) + ext(b_re));
    sum_im = clip(ext(a_im) + ext(b_im));
    d_re   = clip(ext(a_re) - ext(b_re));
    d_im   = clip(ext(a_im) - ext(b_im));
    nd_re  = clip(-ext(d_re));
    nd_im  = clip(-ext(d_im));
    if (!rotate) begin
      dif_re = d_re;
      dif_im = d_im;
    end else if (!inverse) begin
      dif_re = d_im;
      dif_im = nd_re;
    end else begin
      dif_re = nd_im;
      dif_im = d_re;
    end
  end

endmodule

// File: rtl/sdf_bfly_stage.sv
module sdf_bfly_stage
  import sdf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LOG2N = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic                 inverse,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  localparam int AW = LOG2N - 1;
  localparam int WW = 2 * DW;

  logic                 step;
  logic [AW-1:0]        wr_ptr, rd_ptr;
  phase_e               phase;
  logic                 rotate;
  logic signed [DW-1:0] stg_re, stg_im;
  logic [WW-1:0]        rd_word;
  logic signed [DW-1:0] dl_re, dl_im;
  logic signed [DW-1:0] sum_re, sum_im, dif_re, dif_im;

  assign step     = in_valid & out_ready;
  assign in_ready = out_ready;

  bf_seq_ctrl #(.LOG2N(LOG2N)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .phase  (phase),
    .rotate (rotate)
  );

  bf_delay_ram #(.W(WW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (step),
    .waddr (wr_ptr),
    .wdata ({stg_re, stg_im}),
    .raddr (rd_ptr),
    .rdata (rd_word)
  );

  assign dl_re = rd_word[WW-1:DW];
  assign dl_im = rd_word[DW-1:0];

  bf_core #(.DW(DW)) u_core (
    .a_re    (dl_re),
    .a_im    (dl_im),
    .b_re    (in_re),
    .b_im    (in_im),
    .rotate  (rotate),
    .inverse (inverse),
    .sum_re  (sum_re),
    .sum_im  (sum_im),
    .dif_re  (dif_re),
    .dif_im  (dif_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_re <= '0;
      stg_im <= '0;
    end else if (step) begin
      if (phase == PH_MERGE) begin
        stg_re <= dif_re;
        stg_im <= dif_im;
      end else begin
        stg_re <= in_re;
        stg_im <= in_im;
      end
    end
  end

  always_comb begin
    unique case (phase)
      PH_MERGE: begin
        out_re    = sum_re;
        out_im    = sum_im;
        out_valid = in_valid;
      end
      PH_DRAIN: begin
        out_re    = dl_re;
        out_im    = dl_im;
        out_valid = in_valid;
      end
      default: begin
        out_re    = '0;
        out_im    = '0;
        out_valid = 1'b0;
      end
    endcase
  end

  assert_prime_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PRIME) |-> (!out_valid && out_re == '0 && out_im == '0));

  assert_valid_needs_input_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_valid);

  assert_stage_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(stg_re) && $stable(stg_im)));

  assert_merge_valid_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MERGE && in_valid) |-> out_valid);

endmodule

// File: tb/tb_sdf_bfly_stage.sv
module tb_sdf_bfly_stage;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_re = '0;
  logic signed [15:0] in_im = '0;
  logic inverse = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] out_re, out_im;

  always #4 clk = ~clk;

  sdf_bfly_stage dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .inverse(inverse),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int cur_re [1024];
  int cur_im [1024];
  int pd_re  [512];
  int pd_im  [512];
  int bpos = 0;
  bit bflag = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int rnd(input int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:15] % span) - span / 2;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s pos=%0d actual=%0d expected=%0d", tag, bpos, act, exp);
    end
  endtask

  task automatic push(input int re, input int im, input bit inv, input string tag);
    int er, ei, ev, d_re, d_im, f_re, f_im, r_re, r_im;
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    in_re = re[15:0]; in_im = im[15:0]; inverse = inv;
    #1;
    if (bpos < 512) begin
      if (!bflag) begin ev = 0; er = 0; ei = 0; end
      else begin ev = 1; er = pd_re[bpos]; ei = pd_im[bpos]; end
      cur_re[bpos] = re; cur_im[bpos] = im;
    end else begin
      d_re = cur_re[bpos-512]; d_im = cur_im[bpos-512];
      ev = 1; er = sat(d_re + re); ei = sat(d_im + im);
      f_re = sat(d_re - re); f_im = sat(d_im - im);
      r_re = f_re; r_im = f_im;
      if (bpos >= 768) begin
        if (!inv) begin r_re = f_im; r_im = sat(-f_re); end
        else      begin r_re = sat(-f_im); r_im = f_re; end
      end
      pd_re[bpos-512] = r_re; pd_im[bpos-512] = r_im;
    end
    check({tag, " valid"}, int'(out_valid), ev);
    check({tag, " re"}, int'(out_re), er);
    check({tag, " im"}, int'(out_im), ei);
    @(posedge clk);
    bpos++;
    if (bpos == 1024) begin bpos = 0; bflag = 1'b1; end
  endtask

  task automatic stall(input bit downstream);
    @(negedge clk);
    if (downstream) begin
      in_valid = 1'b1; out_ready = 1'b0;
      in_re = 16'sh7abc; in_im = -16'sh1234;
      #1;
      check("R7 in_ready", int'(in_ready), 0);
    end else begin
      in_valid = 1'b0; out_ready = 1'b1;
      in_re = 16'sh1111; in_im = 16'sh2222;
      #1;
      check("R7 out_valid", int'(out_valid), 0);
    end
    @(posedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b1; out_ready = 1'b1;
    in_re = 16'sh0100; in_im = 16'sh0200;
    #1;
    check("R1 valid", int'(out_valid), 0);
    check("R1 re", int'(out_re), 0);
    check("R1 im", int'(out_im), 0);
    check("R1 ready", int'(in_ready), 1);
    in_valid = 1'b0;
  endtask

  task automatic t_ramp_frame;
    for (int i = 0; i < 1024; i++)
      push(i * 16 - 8000, -i * 8 + 300, 1'b0, "R2/R3");
  endtask

  task automatic t_random_frame;
    for (int i = 0; i < 1024; i++)
      push(rnd(30000), rnd(30000), 1'b0, "R4/R5/R8");
  endtask

  task automatic t_extreme_frame;
    for (int i = 0; i < 1024; i++) begin
      int a, b;
      a = (i % 3 == 0) ? 32767 : ((i % 3 == 1) ? -32768 : 20000);
      b = (i % 2 == 0) ? -32768 : 32767;
      if (i >= 512) begin a = -a; b = -b; if (a > 32767) a = 32767; if (b > 32767) b = 32767; end
      push(a, b, 1'(i % 2), "R6/R5");
    end
  endtask

  task automatic t_stall_frame;
    for (int i = 0; i < 1024; i++) begin
      if (i % 7 == 3) stall(1'b0);
      if (i % 11 == 5) stall(1'b1);
      push(rnd(40000), rnd(40000), 1'(i / 100 % 2), "R7");
    end
  endtask

  task automatic t_tail;
    for (int i = 0; i < 512; i++)
      push(0, 0, 1'b0, "R4/R5");
  endtask

  initial begin
    t_reset;
    t_ramp_frame;
    t_random_frame;
    t_extreme_frame;
    t_stall_frame;
    t_tail;
    @(negedge clk);
    in_valid = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired at pos=%0d", bpos);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule